// File: doc/BRIEF.md
# Outbound Link Address Overlay Unit

This block sits on the transmit side of a memory-mapped chip-to-chip link. It turns a local 32-bit request address into the address that travels to the remote device. First a power-of-two keep mask clears the upper address bits that the remote side does not need. Then the requester's 4-bit privilege ID and its security bit are written into chosen upper bit positions of the masked address. The receive side later decodes these bits again.

Three 4-bit selectors in one control register set the behaviour: the mask width, where the privilege field starts, and where the security bit goes. A request enters through a valid/ready handshake. The overlaid address leaves one cycle later through a second valid/ready handshake, held in a single output register. Each request uses the control value that was registered when the request was accepted.

Top module: `addr_ovl_unit`

## Requirements
- R1: The control register holds the mask select in bits 3:0, the privilege position select in bits 11:8 and the security position select in bits 19:16. Every other bit reads as zero. After reset all fields are zero.
- R2: With mask select v, the address is ANDed with (2^(v+17))−1. Value 0 keeps bits 16:0, value 10 keeps 26:0, value 11 keeps 27:0 and value 15 keeps all 32 bits.
- R3: With mask select 11 and privilege select 12, privilege ID 5 and address 0x4567_89A0 give 0x5567_89A0. The ID occupies bits 31:28.
- R4: With privilege select v from 1 to 15, the ID is placed starting at bit v+16. Above bit 31 it is clipped, so only the low 3, 2 or 1 ID bits remain for v = 13, 14 or 15. The ID bits replace the masked address bits at those positions.
- R5: With privilege select 0, no privilege bits are written.
- R6: With security select v from 1 to 15, the security bit replaces address bit v+16. Value 0 writes no security bit.
- R7: Where the security bit and the privilege field overlap, the security bit wins.
- R8: An accepted request appears on the output one cycle later. While out_valid is high and out_ready is low, the output holds stable and in_ready is low. in_ready is high whenever the output register is empty or is being drained.
- R9: A control write takes effect only for requests accepted after the write cycle. A request accepted in the same cycle as the write uses the previous value.
- R10: After reset out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 32 | Control register write value |
| cfg_rd_data | output | 32 | Control register read value |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | 32 | Local request address |
| in_priv | input | 4 | Requester privilege ID |
| in_sec | input | 1 | Requester security bit |
| out_valid | output | 1 | Outgoing address valid |
| out_ready | input | 1 | Downstream can take the address |
| out_addr | output | 32 | Overlaid outgoing link address |

## Verification
The assertions assume that the downstream side follows the handshake and that no input is unknown after reset. The bench changes inputs only on falling edges and holds each request until it is accepted. The field assertions also assume the selectors come from the registered control fields, which hold only 4-bit values. The bench therefore reaches every selector value, including 0 and 15, only through control writes.

// File: rtl/addr_ovl_pkg.sv
package addr_ovl_pkg;
    localparam int ADDR_W   = 32;
    localparam int PRIV_W   = 4;
    localparam int SEL_W    = 4;
    localparam int MASK_MIN = 17;
    localparam int POS_OFF  = 16;

    typedef struct packed {
        logic [SEL_W-1:0] sec_sel;
        logic [SEL_W-1:0] priv_sel;
        logic [SEL_W-1:0] mask_sel;
    } ovl_cfg_t;

    typedef struct packed {
        ovl_cfg_t          cfg;
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } ovl_state_t;
endpackage

// File: rtl/ovl_mask_gen.sv
module ovl_mask_gen #(
    parameter int ADDR_W   = 32,
    parameter int SEL_W    = 4,
    parameter int MASK_MIN = 17
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] mask
);
    localparam int SH_W = $clog2(ADDR_W + 1) + 1;

    logic [ADDR_W:0] wide;
    logic [SH_W-1:0] width;

    always_comb begin
        width = SH_W'(sel) + SH_W'(MASK_MIN);
        wide  = ((ADDR_W+1)'(1) << width) - (ADDR_W+1)'(1);
        mask  = wide[ADDR_W-1:0];
    end

    // R2: top kept bit is set and the next one up is clear
    always_comb begin
        if (!$isunknown(sel)) begin
            a_r2_mask_edge: assert (mask[width-1] == 1'b1 &&
                (width >= SH_W'(ADDR_W) || mask[width] == 1'b0))
                else $error("mask edge wrong");
        end
    end
endmodule

// File: rtl/ovl_field_place.sv
module ovl_field_place #(
    parameter int ADDR_W  = 32,
    parameter int SEL_W   = 4,
    parameter int FIELD_W = 4,
    parameter int POS_OFF = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel,
    input  logic [FIELD_W-1:0] val,
    input  logic [ADDR_W-1:0]  addr_in,
    output logic [ADDR_W-1:0]  addr_out
);
    localparam int SH_W = $clog2(ADDR_W) + 2;

    logic [SH_W-1:0]   start;
    logic [ADDR_W-1:0] fmask;
    logic [ADDR_W-1:0] fval;

    always_comb begin
        start = SH_W'(sel) + SH_W'(POS_OFF);
        fmask = ADDR_W'({FIELD_W{1'b1}}) << start;
        fval  = ADDR_W'(val) << start;
        if (sel == '0) begin
            addr_out = addr_in;
        end else begin
            addr_out = (addr_in & ~fmask) | fval;
        end
    end

    // R5 / R6: a zero selector passes the address through unchanged
    a_r5_zero_sel_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (addr_out == addr_in));
    // R4 / R6: the lowest field bit lands at bit sel+POS_OFF
    a_r4_field_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != '0) |-> (addr_out[start[SH_W-2:0]] == val[0]));
endmodule

// File: rtl/addr_ovl_unit.sv
module addr_ovl_unit
    import addr_ovl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       cfg_rd_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [PRIV_W-1:0] in_priv,
    input  logic              in_sec,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr
);
    ovl_state_t st_d, st_q;

    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] masked;
    logic [ADDR_W-1:0] with_priv;
    logic [ADDR_W-1:0] with_sec;

    ovl_mask_gen #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .MASK_MIN(MASK_MIN)) u_mask (
        .sel  (st_q.cfg.mask_sel),
        .mask (keep_mask)
    );

    assign masked = in_addr & keep_mask;

    ovl_field_place #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .FIELD_W(PRIV_W),
                      .POS_OFF(POS_OFF)) u_priv (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (st_q.cfg.priv_sel),
        .val      (in_priv),
        .addr_in  (masked),
        .addr_out (with_priv)
    );

    ovl_field_place #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .FIELD_W(1),
                      .POS_OFF(POS_OFF)) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (st_q.cfg.sec_sel),
        .val      (in_sec),
        .addr_in  (with_priv),
        .addr_out (with_sec)
    );

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.vld || out_ready;
        if (st_q.vld && out_ready) begin
            st_d.vld = 1'b0;
        end
        if (in_valid && in_ready) begin
            st_d.vld  = 1'b1;
            st_d.addr = with_sec;
        end
        if (cfg_wr_en) begin
            st_d.cfg.mask_sel = cfg_wr_data[3:0];
            st_d.cfg.priv_sel = cfg_wr_data[11:8];
            st_d.cfg.sec_sel  = cfg_wr_data[19:16];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rd_data        = '0;
        cfg_rd_data[3:0]   = st_q.cfg.mask_sel;
        cfg_rd_data[11:8]  = st_q.cfg.priv_sel;
        cfg_rd_data[19:16] = st_q.cfg.sec_sel;
    end

    assign out_valid = st_q.vld;
    assign out_addr  = st_q.addr;

    // R8: a stalled output holds its value and blocks new requests
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));
    a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    a_r8_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
    // R9: a request accepted with a write still sees the old control value
    a_r9_old_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && in_valid && in_ready && $past(rst_n)) |=> (out_addr ==
        ($past(with_sec))));
endmodule

// File: tb/addr_ovl_unit_tb_top.sv
module addr_ovl_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [31:0] cfg_wr_data;
    logic [31:0] cfg_rd_data;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_addr;
    logic [3:0]  in_priv;
    logic        in_sec;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    addr_ovl_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_priv(in_priv), .in_sec(in_sec),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent model, bit by bit from the requirements
    function automatic logic [31:0] model(input logic [3:0] ms, input logic [3:0] ps,
                                          input logic [3:0] ss, input logic [31:0] a,
                                          input logic [3:0] id, input logic sec);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = (i < int'(ms) + 17) ? a[i] : 1'b0;
        if (ps != 0)
            for (int k = 0; k < 4; k++)
                if (int'(ps) + 16 + k < 32) r[int'(ps) + 16 + k] = id[k];
        if (ss != 0) r[int'(ss) + 16] = sec;
        return r;
    endfunction

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic send(input string req, input logic [31:0] a, input logic [3:0] id,
                        input logic sec, input logic [31:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_priv = id; in_sec = sec;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {31'b0, out_valid}, 32'd1);
        check(req, out_addr, exp);
    endtask

    task automatic t_reset;
        check("R10 out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 reset cfg", cfg_rd_data, 32'd0);
        check("R8 ready empty", {31'b0, in_ready}, 32'd1);
    endtask

    task automatic t_cfg_readback;
        write_cfg(32'hFFFF_FFFF);
        check("R1 reserved zero", cfg_rd_data, 32'h000F_0F0F);
        write_cfg(32'h0003_0A05);
        check("R1 field place", cfg_rd_data, 32'h0003_0A05);
    endtask

    task automatic t_mask;
        write_cfg(32'h0000_0000);
        send("R2 sel0", 32'hFFFF_FFFF, 4'h0, 1'b0, 32'h0001_FFFF);
        write_cfg(32'h0000_000A);
        send("R2 sel10", 32'hFFFF_FFFF, 4'h0, 1'b0, 32'h07FF_FFFF);
        write_cfg(32'h0000_000F);
        send("R2 sel15", 32'hFFFF_FFFF, 4'h0, 1'b0, 32'hFFFF_FFFF);
    endtask

    task automatic t_priv;
        write_cfg(32'h0000_0C0B);
        send("R3 example", 32'h4567_89A0, 4'h5, 1'b0, 32'h5567_89A0);
        write_cfg(32'h0000_0D00);
        send("R4 clip3", 32'h0, 4'hF, 1'b0, 32'hE000_0000);
        write_cfg(32'h0000_0F0F);
        send("R4 clip1", 32'h0, 4'hE, 1'b0, 32'h0000_0000);
        write_cfg(32'h0000_0100);
        send("R4 low", 32'h0, 4'hA, 1'b0, 32'h0014_0000);
        write_cfg(32'h0000_070F);
        send("R4 replace", 32'hFFFF_FFFF, 4'h0, 1'b0, 32'hF87F_FFFF);
        write_cfg(32'h0000_000F);
        send("R5 none", 32'h1234_5678, 4'hF, 1'b1, 32'h1234_5678);
    endtask

    task automatic t_sec;
        write_cfg(32'h0001_0000);
        send("R6 bit17", 32'h0, 4'h0, 1'b1, 32'h0002_0000);
        write_cfg(32'h000F_0000);
        send("R6 bit31", 32'h0, 4'h0, 1'b1, 32'h8000_0000);
        write_cfg(32'h000F_000F);
        send("R6 clear", 32'hFFFF_FFFF, 4'h0, 1'b0, 32'h7FFF_FFFF);
        write_cfg(32'h000F_0C00);
        send("R7 overlap", 32'h0, 4'hF, 1'b0, 32'h7000_0000);
        write_cfg(32'h0005_0705);
        send("R6 model", 32'hDEAD_BEEF, 4'h9, 1'b1,
             model(4'h5, 4'h7, 4'h5, 32'hDEAD_BEEF, 4'h9, 1'b1));
    endtask

    task automatic t_backpressure;
        logic [31:0] held;
        write_cfg(32'h0000_0C0B);
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_addr = 32'h0111_1111; in_priv = 4'h3; in_sec = 1'b0;
        @(negedge clk);
        in_addr = 32'h0222_2222;
        check("R8 first out", out_addr, 32'h3111_1111);
        check("R8 stall ready", {31'b0, in_ready}, 32'd0);
        held = out_addr;
        @(negedge clk);
        check("R8 stable", out_addr, held);
        check("R8 still valid", {31'b0, out_valid}, 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 second out", out_addr, 32'h3222_2222);
        @(negedge clk);
        check("R8 drained", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_cfg_timing;
        write_cfg(32'h0000_0C0B);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = 32'h0000_0000;
        in_valid = 1'b1; in_addr = 32'h4567_89A0; in_priv = 4'h5; in_sec = 1'b0;
        @(negedge clk);
        cfg_wr_en = 1'b0; in_valid = 1'b0;
        check("R9 old cfg", out_addr, 32'h5567_89A0);
        send("R9 new cfg", 32'h4567_89A0, 4'h5, 1'b0, 32'h0001_89A0);
    endtask

    initial begin
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0; in_valid = 1'b0;
        in_addr = '0; in_priv = '0; in_sec = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_readback();
        t_mask();
        t_priv();
        t_sec();
        t_backpressure();
        t_cfg_timing();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule